// File: doc/BRIEF.md
# Instruction machine-cycle sequencer

This block is the control sequencer of a classic 8-bit accumulator processor. Every instruction opens with a three-state opcode fetch. The sequencer then looks up the instruction class of the fetched opcode and walks through that class's own list of machine cycles, numbered 1 to 5, each made of T-states numbered 1 to 5. Each class sets how many machine cycles it uses, how long each one is, which register supplies the address, and what kind of bus cycle it is.

In every state the sequencer reports the machine-cycle and T-state numbers. It also reports which address source is selected, the bus cycle kind, and strobes that tell the datapath to advance the program counter or the WZ temporary pair. A `done` pulse marks the final state of an instruction. The datapath, the ALU and the stack instructions are outside this block and are seen only through these control outputs.

The opcode enters through a valid/ready handshake. `op_ready` is high only in the third state of the fetch cycle. If `op_valid` is low there, the sequencer stalls in that state, which gives the memory back-pressure. The opcode is taken on the clock edge where both signals are high. The interrupt-enable flag and the halt state are kept here. Code values used below: address source 0 none, 1 PC, 2 HL, 3 register pair, 5 WZ. Cycle kind 0 internal, 1 opcode fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write, 6 halt acknowledge.

Top module: `sqc_top`

## Requirements
- R1: After reset the outputs show machine cycle 1, T-state 1, address source 1 and cycle kind 1, with `inte` and `halted` low.
- R2: Every instruction starts with T-states 1 to 3 of machine cycle 1. These show source 1 and kind 1, `pc_inc` is high in T-state 2, and `op_ready` is high in T-state 3.
- R3: When `op_ready` is high and `op_valid` is low, the state does not change on the next edge. The opcode is taken on the edge where both are high.
- R4: A register-to-register move 01dddsss (neither field 110) ends in T-state 5 of cycle 1. Any opcode not named in R5 to R11 ends in T-state 4 of cycle 1. Internal T-states show source 0 and kind 0.
- R5: 01ddd110 adds a cycle-2 read from HL, and 01110sss adds a cycle-2 write to HL. 0x0A and 0x1A read through the register pair (source 3), and 0x02 and 0x12 write through it.
- R6: 00ddd110 reads its data byte in cycle 2 from the PC with `pc_inc` in T-state 2. 0x36 adds a cycle-3 write to HL. 00rp0001 reads two bytes from the PC in cycles 2 and 3. Memory and I/O cycles last three T-states.
- R7: 0x3A and 0x32 read two address bytes from the PC, then read or write in cycle 4 through WZ. 0x2A and 0x22 do the same, with `wz_inc` in T-state 2 of cycle 4, and then a second WZ access in cycle 5.
- R8: 0xDB and 0xD3 read the port byte in cycle 2 from the PC, then perform a cycle-3 I/O read (kind 4) or I/O write (kind 5) addressed by WZ.
- R9: After 0xC3, or after 11ccc010 with `cond_true` high in T-state 4 of cycle 1, the next fetch uses source 5. In its T-state 2, `pc_from_wz` is high instead of `pc_inc`. With `cond_true` low, the next fetch uses the PC.
- R10: 0xFB sets `inte` and 0xF3 clears it, in both cases from the state after T-state 4. Reset clears `inte`, even in the middle of an instruction.
- R11: 0x76 runs a cycle-2 halt acknowledge (source 1, kind 6) of two T-states and ends there. After that, `halted` is high and the cycle numbers, source, kind and strobes are all 0.
- R12: While halted the sequencer stays halted until `irq` is high. The state after that is cycle 1, T-state 1 fetching from the PC. `irq` has no effect when the sequencer is not halted.
- R13: `done` is high for exactly one state, the last state of the instruction. The following state is cycle 1, T-state 1, or the halt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_data | input | 8 | Opcode byte from the bus |
| op_valid | input | 1 | Opcode byte present |
| op_ready | output | 1 | Sequencer takes the opcode in this state |
| cond_true | input | 1 | Branch condition from the flags, sampled in T-state 4 of cycle 1 |
| irq | input | 1 | Interrupt request, wakes the halt state |
| m_num | output | 3 | Current machine cycle, 0 when halted |
| t_num | output | 3 | Current T-state, 0 when halted |
| addr_sel | output | 3 | Address source code |
| cyc_kind | output | 3 | Bus cycle kind code |
| pc_inc | output | 1 | Advance PC |
| pc_from_wz | output | 1 | Load PC with WZ plus one |
| wz_inc | output | 1 | Advance WZ |
| inte | output | 1 | Interrupt-enable flag |
| halted | output | 1 | Halt state |
| done | output | 1 | Final state of the instruction |

## Verification
The properties assume that `op_valid` only matters while `op_ready` is high. They also assume that `op_data` and `cond_true` stay steady from the fetch to the end of the instruction, and that `irq` may change in any state. The stimulus follows these assumptions: `op_valid` is raised only in fetch T-state 3, sometimes after several stall states. The opcode and condition are set before each instruction and held until its `done` state. `irq` is driven high during a normal instruction as well as during the halt state.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  localparam int OP_W  = 8;
  localparam int CNT_W = 3;

  localparam logic [CNT_W-1:0] M_FIRST = 3'd1;
  localparam logic [CNT_W-1:0] T_ADV   = 3'd2;
  localparam logic [CNT_W-1:0] T_OPC   = 3'd3;
  localparam logic [CNT_W-1:0] T_DEC   = 3'd4;

  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_PC   = 3'd1;
  localparam logic [2:0] SRC_HL   = 3'd2;
  localparam logic [2:0] SRC_RP   = 3'd3;
  localparam logic [2:0] SRC_WZ   = 3'd5;

  localparam logic [2:0] CK_INT   = 3'd0;
  localparam logic [2:0] CK_FETCH = 3'd1;
  localparam logic [2:0] CK_MRD   = 3'd2;
  localparam logic [2:0] CK_MWR   = 3'd3;
  localparam logic [2:0] CK_IORD  = 3'd4;
  localparam logic [2:0] CK_IOWR  = 3'd5;
  localparam logic [2:0] CK_HALT  = 3'd6;

  typedef enum logic [4:0] {
    IC_NOP, IC_MOVRR, IC_LDHL, IC_STHL, IC_HALT, IC_MVI, IC_MVIM,
    IC_LXI, IC_JMP, IC_JCOND, IC_LDA, IC_STA, IC_LHLD, IC_SHLD,
    IC_LDAX, IC_STAX, IC_IN, IC_OUT, IC_EI, IC_DI
  } iclass_e;

  typedef struct packed {
    iclass_e          cls;
    logic [CNT_W-1:0] m1_len;
    logic [CNT_W-1:0] m_last;
  } iprof_t;

  typedef struct packed {
    logic [2:0]       src;
    logic [2:0]       kind;
    logic             pc_bump;
    logic             wz_bump;
    logic [CNT_W-1:0] t_last;
  } mcyc_t;
endpackage

// File: rtl/sqc_decode.sv
module sqc_decode
  import sqc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output iprof_t          prof
);
  localparam logic [2:0] FLD_MEM = 3'b110;

  iclass_e cls;

  always_comb begin
    cls = IC_NOP;
    if (op == 8'h76)                                      cls = IC_HALT;
    else if (op[7:6] == 2'b01) begin
      if (op[5:3] == FLD_MEM)                             cls = IC_STHL;
      else if (op[2:0] == FLD_MEM)                        cls = IC_LDHL;
      else                                                cls = IC_MOVRR;
    end
    else if (op[7:6] == 2'b00) begin
      if (op[2:0] == FLD_MEM)                             cls = (op[5:3] == FLD_MEM) ? IC_MVIM : IC_MVI;
      else if (op[3:0] == 4'b0001)                        cls = IC_LXI;
      else if (op[7:5] == 3'b000 && op[3:0] == 4'b1010)   cls = IC_LDAX;
      else if (op[7:5] == 3'b000 && op[3:0] == 4'b0010)   cls = IC_STAX;
      else if (op == 8'h3A)                               cls = IC_LDA;
      else if (op == 8'h32)                               cls = IC_STA;
      else if (op == 8'h2A)                               cls = IC_LHLD;
      else if (op == 8'h22)                               cls = IC_SHLD;
    end
    else if (op[7:6] == 2'b11) begin
      if (op == 8'hC3)                                    cls = IC_JMP;
      else if (op[2:0] == 3'b010)                         cls = IC_JCOND;
      else if (op == 8'hDB)                               cls = IC_IN;
      else if (op == 8'hD3)                               cls = IC_OUT;
      else if (op == 8'hFB)                               cls = IC_EI;
      else if (op == 8'hF3)                               cls = IC_DI;
    end
  end

  always_comb begin
    prof.cls    = cls;
    prof.m1_len = (cls == IC_MOVRR) ? 3'd5 : 3'd4;
    unique case (cls)
      IC_LDHL, IC_STHL, IC_HALT, IC_MVI, IC_LDAX, IC_STAX: prof.m_last = 3'd2;
      IC_MVIM, IC_LXI, IC_JMP, IC_JCOND, IC_IN, IC_OUT:    prof.m_last = 3'd3;
      IC_LDA, IC_STA:                                      prof.m_last = 3'd4;
      IC_LHLD, IC_SHLD:                                    prof.m_last = 3'd5;
      default:                                             prof.m_last = 3'd1;
    endcase
  end
endmodule

// File: rtl/sqc_cycle.sv
module sqc_cycle
  import sqc_pkg::*;
(
  input  iclass_e          cls,
  input  logic [CNT_W-1:0] m,
  output mcyc_t            d
);
  logic from_pc;

  always_comb begin
    from_pc = 1'b0;
    unique case (cls)
      IC_MVI, IC_MVIM, IC_IN, IC_OUT:               from_pc = (m == 3'd2);
      IC_LXI, IC_JMP, IC_JCOND, IC_LDA, IC_STA,
      IC_LHLD, IC_SHLD:                             from_pc = (m == 3'd2) || (m == 3'd3);
      default:                                      from_pc = 1'b0;
    endcase
  end

  always_comb begin
    d.src     = SRC_NONE;
    d.kind    = CK_INT;
    d.pc_bump = 1'b0;
    d.wz_bump = 1'b0;
    d.t_last  = 3'd3;
    if (from_pc) begin
      d.src     = SRC_PC;
      d.kind    = CK_MRD;
      d.pc_bump = 1'b1;
    end else begin
      unique case (cls)
        IC_LDHL: begin d.src = SRC_HL; d.kind = CK_MRD; end
        IC_STHL: begin d.src = SRC_HL; d.kind = CK_MWR; end
        IC_MVIM: begin d.src = SRC_HL; d.kind = CK_MWR; end
        IC_LDAX: begin d.src = SRC_RP; d.kind = CK_MRD; end
        IC_STAX: begin d.src = SRC_RP; d.kind = CK_MWR; end
        IC_HALT: begin d.src = SRC_PC; d.kind = CK_HALT; d.t_last = 3'd2; end
        IC_LDA:  begin d.src = SRC_WZ; d.kind = CK_MRD; end
        IC_STA:  begin d.src = SRC_WZ; d.kind = CK_MWR; end
        IC_LHLD: begin d.src = SRC_WZ; d.kind = CK_MRD; d.wz_bump = (m == 3'd4); end
        IC_SHLD: begin d.src = SRC_WZ; d.kind = CK_MWR; d.wz_bump = (m == 3'd4); end
        IC_IN:   begin d.src = SRC_WZ; d.kind = CK_IORD; end
        IC_OUT:  begin d.src = SRC_WZ; d.kind = CK_IOWR; end
        default: begin end
      endcase
    end
  end
endmodule

// File: rtl/sqc_core.sv
module sqc_core
  import sqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             cond_true,
  input  logic             irq,
  input  iprof_t           prof_in,
  input  mcyc_t            cyc,
  output iclass_e          cls_o,
  output logic [CNT_W-1:0] m_o,
  output logic             op_ready,
  output logic [CNT_W-1:0] m_num,
  output logic [CNT_W-1:0] t_num,
  output logic [2:0]       addr_sel,
  output logic [2:0]       cyc_kind,
  output logic             pc_inc,
  output logic             pc_from_wz,
  output logic             wz_inc,
  output logic             inte,
  output logic             halted,
  output logic             done
);
  logic [CNT_W-1:0] m_q, t_q, m1len_q, mlast_q, t_lim;
  iclass_e          cls_q;
  logic             jmp_q, inte_q, halt_q;
  logic             in_m1, t_end, stall, last, accept;

  always_comb begin
    in_m1  = (m_q == M_FIRST);
    t_lim  = in_m1 ? m1len_q : cyc.t_last;
    t_end  = (t_q == t_lim);
    accept = !halt_q && in_m1 && (t_q == T_OPC) && op_valid;
    stall  = !halt_q && in_m1 && (t_q == T_OPC) && !op_valid;
    last   = !halt_q && t_end && (m_q == mlast_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q     <= M_FIRST;
      t_q     <= 3'd1;
      cls_q   <= IC_NOP;
      m1len_q <= 3'd4;
      mlast_q <= 3'd1;
      jmp_q   <= 1'b0;
      inte_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else if (halt_q) begin
      if (irq) halt_q <= 1'b0;
    end else begin
      if (accept) begin
        cls_q   <= prof_in.cls;
        m1len_q <= prof_in.m1_len;
        mlast_q <= prof_in.m_last;
        jmp_q   <= 1'b0;
      end
      if (in_m1 && t_q == T_DEC) begin
        unique case (cls_q)
          IC_EI:    inte_q <= 1'b1;
          IC_DI:    inte_q <= 1'b0;
          IC_JMP:   jmp_q  <= 1'b1;
          IC_JCOND: jmp_q  <= cond_true;
          default:  begin end
        endcase
      end
      if (stall) begin
        t_q <= t_q;
      end else if (last) begin
        m_q <= M_FIRST;
        t_q <= 3'd1;
        if (cls_q == IC_HALT) halt_q <= 1'b1;
      end else if (t_end) begin
        m_q <= m_q + 3'd1;
        t_q <= 3'd1;
      end else begin
        t_q <= t_q + 3'd1;
      end
    end
  end

  always_comb begin
    cls_o      = cls_q;
    m_o        = m_q;
    m_num      = halt_q ? '0 : m_q;
    t_num      = halt_q ? '0 : t_q;
    addr_sel   = SRC_NONE;
    cyc_kind   = CK_INT;
    pc_inc     = 1'b0;
    pc_from_wz = 1'b0;
    wz_inc     = 1'b0;
    op_ready   = 1'b0;
    if (!halt_q) begin
      if (in_m1) begin
        if (t_q <= T_OPC) begin
          addr_sel   = jmp_q ? SRC_WZ : SRC_PC;
          cyc_kind   = CK_FETCH;
          pc_inc     = (t_q == T_ADV) && !jmp_q;
          pc_from_wz = (t_q == T_ADV) && jmp_q;
          op_ready   = (t_q == T_OPC);
        end
      end else begin
        addr_sel = cyc.src;
        cyc_kind = cyc.kind;
        pc_inc   = (t_q == T_ADV) && cyc.pc_bump;
        wz_inc   = (t_q == T_ADV) && cyc.wz_bump;
      end
    end
    inte   = inte_q;
    halted = halt_q;
    done   = last;
  end
endmodule

// File: rtl/sqc_top.sv
module sqc_top
  import sqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_data,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             cond_true,
  input  logic             irq,
  output logic [CNT_W-1:0] m_num,
  output logic [CNT_W-1:0] t_num,
  output logic [2:0]       addr_sel,
  output logic [2:0]       cyc_kind,
  output logic             pc_inc,
  output logic             pc_from_wz,
  output logic             wz_inc,
  output logic             inte,
  output logic             halted,
  output logic             done
);
  iprof_t           prof;
  mcyc_t            cyc;
  iclass_e          cls_cur;
  logic [CNT_W-1:0] m_cur;

  sqc_decode i_decode (.op(op_data), .prof(prof));

  sqc_cycle i_cycle (.cls(cls_cur), .m(m_cur), .d(cyc));

  sqc_core i_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_true(cond_true),
    .irq(irq), .prof_in(prof), .cyc(cyc), .cls_o(cls_cur), .m_o(m_cur),
    .op_ready(op_ready), .m_num(m_num), .t_num(t_num), .addr_sel(addr_sel),
    .cyc_kind(cyc_kind), .pc_inc(pc_inc), .pc_from_wz(pc_from_wz),
    .wz_inc(wz_inc), .inte(inte), .halted(halted), .done(done)
  );
endmodule

// File: rtl/sqc_chk.sv
module sqc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic       irq,
  input logic [2:0] m_num,
  input logic [2:0] t_num,
  input logic [2:0] addr_sel,
  input logic [2:0] cyc_kind,
  input logic       pc_inc,
  input logic       pc_from_wz,
  input logic       wz_inc,
  input logic       halted,
  input logic       done
);
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && !op_valid) |=> (op_ready && $stable(m_num) && $stable(t_num)));

  assert_internal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_num == 3'd1 && t_num >= 3'd4) |-> (addr_sel == 3'd0 && cyc_kind == 3'd0));

  assert_bump_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_inc, pc_from_wz, wz_inc}));

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (addr_sel == 3'd0 && cyc_kind == 3'd0 && !done && !op_ready));

  assert_halt_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !irq) |=> halted);

  assert_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && irq) |=> (!halted && m_num == 3'd1 && t_num == 3'd1));

  assert_done_next_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && (halted || (m_num == 3'd1 && t_num == 3'd1))));

  assert_progress_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !done && !(op_ready && !op_valid)) |=>
      ((t_num == $past(t_num) + 3'd1 && m_num == $past(m_num)) ||
       (t_num == 3'd1 && m_num == $past(m_num) + 3'd1)));
endmodule

bind sqc_top sqc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .irq(irq),
  .m_num(m_num), .t_num(t_num), .addr_sel(addr_sel), .cyc_kind(cyc_kind),
  .pc_inc(pc_inc), .pc_from_wz(pc_from_wz), .wz_inc(wz_inc),
  .halted(halted), .done(done)
);

// File: tb/test_sqc_top.sv
module test_sqc_top;
  logic       clk = 1'b0;
  logic       rst_n, op_valid, cond_true, irq;
  logic [7:0] op_data;
  logic       op_ready, pc_inc, pc_from_wz, wz_inc, inte, halted, done;
  logic [2:0] m_num, t_num, addr_sel, cyc_kind;

  always #2 clk = ~clk;

  sqc_top i_sqc_top (
    .clk(clk), .rst_n(rst_n), .op_data(op_data), .op_valid(op_valid),
    .op_ready(op_ready), .cond_true(cond_true), .irq(irq), .m_num(m_num),
    .t_num(t_num), .addr_sel(addr_sel), .cyc_kind(cyc_kind), .pc_inc(pc_inc),
    .pc_from_wz(pc_from_wz), .wz_inc(wz_inc), .inte(inte), .halted(halted),
    .done(done)
  );

  typedef struct {
    logic [2:0] m, t, src, kind;
    logic pci, pcw, wzi, rdy, dn, hlt, ie, vin, irqin;
    string tag;
  } item_t;

  item_t expq[$];
  item_t pend[$];
  int    n_chk = 0, n_bad = 0, n_cyc = 0;
  logic  exp_ie = 1'b0, exp_jmp = 1'b0, cur_irq = 1'b0;

  // monitor: one scoreboard check per state
  always @(negedge clk) begin
    item_t e;
    logic [18:0] act, exv;
    if (rst_n && expq.size() > 0) begin
      e   = expq.pop_front();
      act = {m_num, t_num, addr_sel, cyc_kind, pc_inc, pc_from_wz, wz_inc, op_ready, done, halted, inte};
      exv = {e.m, e.t, e.src, e.kind, e.pci, e.pcw, e.wzi, e.rdy, e.dn, e.hlt, e.ie};
      n_chk++;
      if (act !== exv) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", e.tag, act, exv);
      end
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog R13 actual=%0d cycles expected<20000", n_cyc);
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [2:0] m, t, src, kind,
                     input logic pci, pcw, wzi, rdy, vin, input string tag);
    item_t it;
    it.m = m; it.t = t; it.src = src; it.kind = kind;
    it.pci = pci; it.pcw = pcw; it.wzi = wzi; it.rdy = rdy;
    it.dn = 1'b0; it.hlt = 1'b0; it.ie = exp_ie;
    it.vin = vin; it.irqin = cur_irq; it.tag = tag;
    pend.push_back(it);
  endtask

  task automatic put_h(input logic irqin, input string tag);
    item_t it;
    it.m = 0; it.t = 0; it.src = 0; it.kind = 0;
    it.pci = 0; it.pcw = 0; it.wzi = 0; it.rdy = 0;
    it.dn = 0; it.hlt = 1'b1; it.ie = exp_ie;
    it.vin = 0; it.irqin = irqin; it.tag = tag;
    pend.push_back(it);
  endtask

  task automatic start(input logic [7:0] op, input logic c);
    op_data = op; cond_true = c;
  endtask

  task automatic fetch(input int stalls, input string tag);
    logic [2:0] s;
    s = exp_jmp ? 3'd5 : 3'd1;
    put(1, 1, s, 1, 0, 0, 0, 0, 0, tag);
    put(1, 2, s, 1, !exp_jmp, exp_jmp, 0, 0, 0, exp_jmp ? "R9" : tag);
    for (int k = 0; k < stalls; k++) put(1, 3, s, 1, 0, 0, 0, 1, 0, "R3");
    put(1, 3, s, 1, 0, 0, 0, 1, 1, tag);
    exp_jmp = 1'b0;
  endtask

  task automatic idle(input logic [2:0] t, input string tag);
    put(1, t, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic bus(input logic [2:0] m, src, kind, input logic pci, wzi, input string tag);
    put(m, 1, src, kind, 0, 0, 0, 0, 0, tag);
    put(m, 2, src, kind, pci, 0, wzi, 0, 0, tag);
    put(m, 3, src, kind, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic commit(input logic mark);
    if (mark) pend[pend.size()-1].dn = 1'b1;
    for (int i = 0; i < pend.size(); i++) expq.push_back(pend[i]);
    for (int i = 0; i < pend.size(); i++) begin
      op_valid = pend[i].vin;
      irq      = pend[i].irqin;
      @(posedge clk); #1;
    end
    op_valid = 1'b0; irq = 1'b0;
    pend.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_valid = 1'b0; irq = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    exp_ie = 1'b0; exp_jmp = 1'b0;
  endtask

  task automatic plain(input logic [7:0] op, input string tag);
    start(op, 1'b0); fetch(0, tag); idle(4, tag); commit(1);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; irq = 1'b0; op_data = 8'h00; cond_true = 1'b0;
    @(posedge clk); #1;
    do_reset();

    plain(8'h00, "R1");                                   // first fetch shows reset state
    plain(8'h07, "R4");                                   // unlisted opcode: four states

    start(8'h78, 0); fetch(0, "R2"); idle(4, "R4"); idle(5, "R13"); commit(1);

    start(8'h7E, 0); fetch(0, "R5"); idle(4, "R5"); bus(2, 2, 2, 0, 0, "R5"); commit(1);
    cur_irq = 1'b1;                                       // irq ignored while running (R12)
    start(8'h77, 0); fetch(1, "R12"); idle(4, "R12"); bus(2, 2, 3, 0, 0, "R12"); commit(1);
    cur_irq = 1'b0;
    start(8'h1A, 0); fetch(0, "R5"); idle(4, "R5"); bus(2, 3, 2, 0, 0, "R5"); commit(1);
    start(8'h02, 0); fetch(0, "R5"); idle(4, "R5"); bus(2, 3, 3, 0, 0, "R5"); commit(1);

    start(8'h3E, 0); fetch(0, "R6"); idle(4, "R6"); bus(2, 1, 2, 1, 0, "R6"); commit(1);
    start(8'h36, 0); fetch(2, "R3"); idle(4, "R6"); bus(2, 1, 2, 1, 0, "R6");
    bus(3, 2, 3, 0, 0, "R6"); commit(1);
    start(8'h21, 0); fetch(0, "R6"); idle(4, "R6"); bus(2, 1, 2, 1, 0, "R6");
    bus(3, 1, 2, 1, 0, "R6"); commit(1);

    start(8'h3A, 0); fetch(0, "R7"); idle(4, "R7"); bus(2, 1, 2, 1, 0, "R7");
    bus(3, 1, 2, 1, 0, "R7"); bus(4, 5, 2, 0, 0, "R7"); commit(1);
    start(8'h32, 0); fetch(0, "R7"); idle(4, "R7"); bus(2, 1, 2, 1, 0, "R7");
    bus(3, 1, 2, 1, 0, "R7"); bus(4, 5, 3, 0, 0, "R7"); commit(1);
    start(8'h2A, 0); fetch(0, "R7"); idle(4, "R7"); bus(2, 1, 2, 1, 0, "R7");
    bus(3, 1, 2, 1, 0, "R7"); bus(4, 5, 2, 0, 1, "R7"); bus(5, 5, 2, 0, 0, "R7"); commit(1);
    start(8'h22, 0); fetch(0, "R7"); idle(4, "R7"); bus(2, 1, 2, 1, 0, "R7");
    bus(3, 1, 2, 1, 0, "R7"); bus(4, 5, 3, 0, 1, "R7"); bus(5, 5, 3, 0, 0, "R7"); commit(1);

    start(8'hDB, 0); fetch(0, "R8"); idle(4, "R8"); bus(2, 1, 2, 1, 0, "R8");
    bus(3, 5, 4, 0, 0, "R8"); commit(1);
    start(8'hD3, 0); fetch(0, "R8"); idle(4, "R8"); bus(2, 1, 2, 1, 0, "R8");
    bus(3, 5, 5, 0, 0, "R8"); commit(1);

    start(8'hC3, 0); fetch(0, "R9"); idle(4, "R9"); bus(2, 1, 2, 1, 0, "R9");
    bus(3, 1, 2, 1, 0, "R9"); commit(1); exp_jmp = 1'b1;
    plain(8'h00, "R9");                                   // redirected fetch
    start(8'hC2, 0); fetch(0, "R9"); idle(4, "R9"); bus(2, 1, 2, 1, 0, "R9");
    bus(3, 1, 2, 1, 0, "R9"); commit(1);
    plain(8'h00, "R9");                                   // not taken: PC fetch
    start(8'hCA, 1); fetch(0, "R9"); idle(4, "R9"); bus(2, 1, 2, 1, 0, "R9");
    bus(3, 1, 2, 1, 0, "R9"); commit(1); exp_jmp = 1'b1;
    start(8'h41, 0); fetch(0, "R9"); idle(4, "R4"); idle(5, "R13"); commit(1);

    plain(8'hFB, "R10"); exp_ie = 1'b1;
    plain(8'h00, "R10");
    plain(8'hF3, "R10"); exp_ie = 1'b0;
    plain(8'h00, "R10");
    plain(8'hFB, "R10"); exp_ie = 1'b1;
    start(8'h00, 0);
    put(1, 1, 1, 1, 0, 0, 0, 0, 0, "R10"); put(1, 2, 1, 1, 1, 0, 0, 0, 0, "R10");
    commit(0);
    do_reset();                                           // mid-instruction reset
    plain(8'h00, "R10");

    plain(8'hFB, "R10"); exp_ie = 1'b1;
    start(8'h76, 0); fetch(0, "R11"); idle(4, "R11");
    put(2, 1, 1, 6, 0, 0, 0, 0, 0, "R11"); put(2, 2, 1, 6, 0, 0, 0, 0, 0, "R11");
    commit(1);
    put_h(0, "R11"); put_h(0, "R12"); put_h(0, "R12"); put_h(1, "R12");
    commit(0);
    plain(8'h00, "R12");                                  // wake: fetch from PC

    repeat (2) @(posedge clk);
    n_chk++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R13 actual=%0d expected=0 pending states", expq.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule